// File: doc/BRIEF.md
# Page-Mode Parallel Memory Controller

This block sits between a synchronous host port and an asynchronous, SRAM-style byte-wide nonvolatile memory. The host offers one byte request at a time over a valid/ready handshake: a write, or a read that later returns its data with a one-cycle response strobe. The controller turns each request into chip-enable, output-enable and write-enable strobes on the memory pins. Every pulse width is a whole number of clock cycles, and each width is set by a parameter.

The memory address splits into a row field in the upper bits and a column field in the low `COL_W` bits. The controller keeps a record of which row is currently open. When a request falls in that row, chip enable stays low and only a short column cycle runs. When the row differs, or when no row is open (as after reset), chip enable is raised for a precharge interval. The new row is then opened and the access follows.

Reads drive output enable low for the access time and capture the bus into a host-side register. Writes drive the data bus, pulse write enable low, and hold the data for one cycle after write enable rises, which is the edge that commits the byte.

Top module: `pgmem_ctrl`

## Requirements
- R1: While reset is applied and in the first idle cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: A request whose row (`req_addr[ADDR_W-1:COL_W]`) differs from the open row, or that arrives while no row is open, holds `mem_ce_n` high for at least `T_PRE` cycles before the access. Its read latency, from the accepting edge to the edge that raises `rsp_valid`, is `T_PRE+T_ACC` cycles. Its write occupies `T_PRE+T_WP+2` cycles until `req_ready` returns.
- R3: A request to the open row keeps `mem_ce_n` low with no precharge. Its read latency is `T_ACC` cycles and its write occupancy is `T_WP+2` cycles.
- R4: A read holds `mem_oe_n` low for `T_ACC` cycles. It returns the byte stored at the address on `rsp_rdata`, with `rsp_valid` high for exactly one cycle.
- R5: A write presents address and data one cycle before `mem_we_n` falls and holds `mem_we_n` low for `T_WP` cycles. It keeps the data driven for one cycle after the rise, and the memory then holds the written byte at that address.
- R6: `mem_oe_n` and `mem_we_n` are never low together. While `mem_we_n` is low, the data bus carries the write data.
- R7: `mem_addr` does not change while `mem_oe_n` or `mem_we_n` stays low from one cycle to the next.
- R8: `req_ready` is high exactly when the controller is idle. A request offered in the same cycle as a read response is accepted in that cycle.
- R9: Row and column are the upper `ADDR_W-COL_W` bits and the low `COL_W` bits of the address. Addresses that differ only in the column bits count as the same row.
- R10: A reset closes the open row, so the first access after any reset takes the precharge path of R2. Memory contents are not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data bus |

## Verification
Two pairs of functions can fall in the same cycle. The first is a read response strobe and the acceptance of the next request: the bench offers each new request at the very negedge where it sees `rsp_valid`, so a request is always waiting when the response appears. It then checks that `req_ready` was high, that the response data was correct, and that the following request's latency still matches its row-hit or row-miss class. The second is closing an open row and accepting a new one: stride and row-alternating sweeps produce back-to-back misses. The bench counts the high-going edges of `mem_ce_n`, measures the length of each high interval, and compares both with values derived from its own record of the open row.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE   = 3'd0,
      SEQ_PRE    = 3'd1,
      SEQ_READ   = 3'd2,
      SEQ_WSETUP = 3'd3,
      SEQ_WPULSE = 3'd4,
      SEQ_WRECOV = 3'd5
   } seq_state_t;

   // Bits needed to hold the value maxv.
   function automatic int count_bits(input int maxv);
      int b;
      b = 1;
      while ((1 << b) <= maxv) b++;
      return b;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pgmem_timer.sv
module pgmem_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // Final cycle of an interval of load_val cycles.
   assign last = (cnt_q == CNT_W'(1));

   // R2: the sequencer only reloads once the running interval has expired.
   a_r2_reload_at_expiry: assert property (@(posedge clk) disable iff (rst)
      load |-> (cnt_q <= CNT_W'(1)));

   // R4: an interval of zero cycles would never assert last.
   a_r4_nonzero_interval: assert property (@(posedge clk) disable iff (rst)
      load |-> (load_val != '0));

endmodule

// File: rtl/pgmem_row_track.sv
module pgmem_row_track #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ROW_W-1:0] probe_row,
   input  logic             open_en,
   input  logic [ROW_W-1:0] open_row,
   input  logic             close_en,
   output logic             row_open,
   output logic             hit
);

   logic [ROW_W-1:0] row_q;
   logic             open_q;
   logic [ROW_W-1:0] bit_eq;

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (close_en) begin
         open_q <= 1'b0;
      end else if (open_en) begin
         open_q <= 1'b1;
         row_q  <= open_row;
      end
   end

   generate
      for (genvar g = 0; g < ROW_W; g++) begin : g_cmp
         assign bit_eq[g] = (row_q[g] == probe_row[g]);
      end
   endgenerate

   assign row_open = open_q;
   assign hit      = open_q && (&bit_eq);

   // R2: a row is never closed and opened in the same cycle.
   a_r2_open_close_excl: assert property (@(posedge clk) disable iff (rst)
      !(open_en && close_en));

   // R10: opening a row records exactly the row presented.
   a_r10_open_records_row: assert property (@(posedge clk) disable iff (rst)
      (open_en && !close_en) |=> (row_open && row_q == $past(open_row)));

endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
   import pgmem_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int T_PRE = 4,
   parameter int T_ACC = 3,
   parameter int T_WP  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_we,
   input  logic             row_hit,
   input  logic             t_last,
   output seq_state_t       state,
   output logic             req_ready,
   output logic             accept,
   output logic             t_load,
   output logic [CNT_W-1:0] t_val,
   output logic             row_close,
   output logic             row_open_en,
   output logic             capture
);

   seq_state_t state_q, state_d;
   logic       we_q;

   assign state     = state_q;
   assign req_ready = (state_q == SEQ_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         we_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) we_q <= req_we;
      end
   end

   always_comb begin
      state_d     = state_q;
      t_load      = 1'b0;
      t_val       = '0;
      row_close   = 1'b0;
      row_open_en = 1'b0;
      capture     = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (accept) begin
               if (!row_hit) begin
                  state_d   = SEQ_PRE;
                  t_load    = 1'b1;
                  t_val     = CNT_W'(T_PRE);
                  row_close = 1'b1;
               end else if (req_we) begin
                  state_d = SEQ_WSETUP;
               end else begin
                  state_d = SEQ_READ;
                  t_load  = 1'b1;
                  t_val   = CNT_W'(T_ACC);
               end
            end
         end
         SEQ_PRE: begin
            if (t_last) begin
               row_open_en = 1'b1;
               if (we_q) begin
                  state_d = SEQ_WSETUP;
               end else begin
                  state_d = SEQ_READ;
                  t_load  = 1'b1;
                  t_val   = CNT_W'(T_ACC);
               end
            end
         end
         SEQ_READ: begin
            if (t_last) begin
               capture = 1'b1;
               state_d = SEQ_IDLE;
            end
         end
         SEQ_WSETUP: begin
            state_d = SEQ_WPULSE;
            t_load  = 1'b1;
            t_val   = CNT_W'(T_WP);
         end
         SEQ_WPULSE: begin
            if (t_last) state_d = SEQ_WRECOV;
         end
         SEQ_WRECOV: begin
            state_d = SEQ_IDLE;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   // R2: a request outside the open row enters precharge next cycle.
   a_r2_miss_enters_pre: assert property (@(posedge clk) disable iff (rst)
      (accept && !row_hit) |=> (state_q == SEQ_PRE));

   // R3: a request inside the open row skips precharge.
   a_r3_hit_skips_pre: assert property (@(posedge clk) disable iff (rst)
      (accept && row_hit) |=> (state_q != SEQ_PRE));

   // R5: the write strobe is always preceded by a setup cycle.
   a_r5_setup_before_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(state_q == SEQ_WPULSE) |-> ($past(state_q) == SEQ_WSETUP));

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
   import pgmem_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   parameter int COL_W  = 3,
   parameter int T_PRE  = 4,
   parameter int T_ACC  = 3,
   parameter int T_WP   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int ROW_W = ADDR_W - COL_W;
   localparam int CNT_W = count_bits(max3(T_PRE, T_ACC, T_WP));

   initial begin : p_param_check
      assert (COL_W >= 1 && COL_W < ADDR_W) else $error("COL_W must lie in 1..ADDR_W-1");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (T_PRE >= 1 && T_ACC >= 1 && T_WP >= 1) else $error("timing counts must be at least 1");
   end

   seq_state_t        state;
   logic              accept, t_load, t_last, row_close, row_open_en, capture;
   logic              row_hit, row_open;
   logic [CNT_W-1:0]  t_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              rsp_q;
   logic              dq_drv;

   pgmem_seq #(
      .CNT_W (CNT_W),
      .T_PRE (T_PRE),
      .T_ACC (T_ACC),
      .T_WP  (T_WP)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid),
      .req_we      (req_we),
      .row_hit     (row_hit),
      .t_last      (t_last),
      .state       (state),
      .req_ready   (req_ready),
      .accept      (accept),
      .t_load      (t_load),
      .t_val       (t_val),
      .row_close   (row_close),
      .row_open_en (row_open_en),
      .capture     (capture)
   );

   pgmem_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   pgmem_row_track #(
      .ROW_W (ROW_W)
   ) u_rows (
      .clk       (clk),
      .rst       (rst),
      .probe_row (req_addr[ADDR_W-1:COL_W]),
      .open_en   (row_open_en),
      .open_row  (addr_q[ADDR_W-1:COL_W]),
      .close_en  (row_close),
      .row_open  (row_open),
      .hit       (row_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= capture;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= mem_dq;
      end
   end

   assign dq_drv    = (state == SEQ_WSETUP) || (state == SEQ_WPULSE) || (state == SEQ_WRECOV);
   assign mem_dq    = dq_drv ? wdata_q : {DATA_W{1'bz}};
   assign mem_ce_n  = !row_open;
   assign mem_oe_n  = (state != SEQ_READ);
   assign mem_we_n  = (state != SEQ_WPULSE);
   assign mem_addr  = addr_q;
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata_q;

   // R6: read and write strobes never overlap.
   a_r6_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n));

   // R6: the data bus is driven throughout the write strobe.
   a_r6_drive_during_we: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (dq_drv && mem_oe_n));

   // R7: column held stable while a strobe stays asserted.
   a_r7_addr_stable_rd: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |=> (mem_oe_n || $stable(mem_addr)));
   a_r7_addr_stable_wr: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |=> (mem_we_n || $stable(mem_addr)));

   // R5: write data held from the strobe through recovery.
   a_r5_wdata_held: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |=> $stable(wdata_q));

   // R4: response strobe lasts one cycle.
   a_r4_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);

   // R8: the response appears while the controller is ready for more.
   a_r8_rsp_while_ready: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> req_ready);

   // R3: a row hit keeps chip enable low into the access.
   a_r3_hit_keeps_ce: assert property (@(posedge clk) disable iff (rst)
      (accept && row_hit) |=> !mem_ce_n);

   // R2: chip enable high while precharging.
   a_r2_ce_high_in_pre: assert property (@(posedge clk) disable iff (rst)
      (state == SEQ_PRE) |-> mem_ce_n);

endmodule

// File: tb/tb_pgmem_ctrl.sv
module tb_pgmem_ctrl;

   localparam int AW    = 7;
   localparam int DW    = 8;
   localparam int CW    = 3;
   localparam int TP    = 3;
   localparam int TA    = 2;
   localparam int TW    = 2;
   localparam int DEPTH = 1 << AW;
   localparam int NCOL  = 1 << CW;
   localparam int NROW  = DEPTH / NCOL;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;

   always #10 clk = ~clk;

   pgmem_ctrl #(
      .ADDR_W (AW), .DATA_W (DW), .COL_W (CW),
      .T_PRE (TP), .T_ACC (TA), .T_WP (TW)
   ) dut (
      .clk (clk), .rst (rst),
      .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
      .mem_addr (mem_addr), .mem_dq (mem_dq)
   );

   // Memory model: drives the bus on reads, commits on the write-enable rise.
   logic [DW-1:0] model [DEPTH];
   assign mem_dq = (!mem_oe_n && !mem_ce_n && mem_we_n) ? model[mem_addr] : {DW{1'bz}};
   always @(posedge mem_we_n) begin
      if (mem_ce_n === 1'b0) model[mem_addr] <= mem_dq;
   end

   int            errors = 0;
   int            checks = 0;
   logic [DW-1:0] shadow [DEPTH];
   bit            exp_open = 1'b0;
   logic [AW-CW-1:0] exp_row = '0;
   int            exp_rises = 0;
   logic [DW-1:0] cur_wdata = '0;
   bit            done_flag = 1'b0;

   // Pin monitors
   int   overlap_cnt = 0, addr_move_cnt = 0, bus_bad_cnt = 0, pre_short_cnt = 0;
   int   ce_rises = 0, ce_run = 0;
   logic ce_prev = 1'b1;
   logic act_prev = 1'b0;
   logic [AW-1:0] addr_prev = '0;

   always @(negedge clk) begin
      if (!rst) begin
         if (!mem_oe_n && !mem_we_n) overlap_cnt++;
         if (act_prev && (!mem_oe_n || !mem_we_n) && mem_addr != addr_prev) addr_move_cnt++;
         if (!mem_we_n && mem_dq !== cur_wdata) bus_bad_cnt++;
         if (mem_ce_n && !ce_prev) ce_rises++;
         if (!mem_ce_n && ce_prev && ce_run < TP) pre_short_cnt++;
         ce_run = mem_ce_n ? ce_run + 1 : 0;
      end
      ce_prev   = mem_ce_n;
      act_prev  = !mem_oe_n || !mem_we_n;
      addr_prev = mem_addr;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(mem_ce_n === 1'b1, {tag, " ce_n"}, int'(mem_ce_n), 1);
      chk(mem_we_n === 1'b1, {tag, " we_n"}, int'(mem_we_n), 1);
      chk(mem_oe_n === 1'b1, {tag, " oe_n"}, int'(mem_oe_n), 1);
      chk(req_ready === 1'b1, {tag, " ready"}, int'(req_ready), 1);
      chk(rsp_valid === 1'b0, {tag, " rsp_valid"}, int'(rsp_valid), 0);
   endtask

   // Called just after a negedge; returns at a negedge.
   task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit miss;
      int n, expl;
      miss = !exp_open || (exp_row != a[AW-1:CW]);
      if (miss && exp_open) exp_rises++;
      if (we) cur_wdata = d;
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      exp_open = 1'b1;
      exp_row  = a[AW-1:CW];
      chk(rsp_valid == 1'b0, "R4 strobe width", int'(rsp_valid), 0);
      n = 1;
      if (!we) begin
         while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
         expl = (miss ? TP : 0) + TA;
         chk(n - 1 == expl, miss ? "R2 read latency" : "R3,R9 read latency", n - 1, expl);
         chk(rsp_rdata == shadow[a], "R4 read data", int'(rsp_rdata), int'(shadow[a]));
         chk(req_ready == 1'b1, "R8 ready with response", int'(req_ready), 1);
      end else begin
         while (!req_ready && n < 100) begin @(negedge clk); n++; end
         expl = (miss ? TP : 0) + TW + 2;
         chk(n - 1 == expl, miss ? "R2 write occupancy" : "R3,R9 write occupancy", n - 1, expl);
         chk(model[a] == d, "R5 stored byte", int'(model[a]), int'(d));
         shadow[a] = d;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk_idle("R1 during reset");
      rst = 1'b0;
      @(negedge clk);
      chk_idle("R1 after reset");

      // Sequential fill: one miss per row, hits for the rest.
      for (int i = 0; i < DEPTH; i++) issue(1'b1, AW'(i), DW'(i * 29 + 5));
      // Sequential readback.
      for (int i = 0; i < DEPTH; i++) issue(1'b0, AW'(i), 'x);
      // Strided readback, mostly row changes.
      for (int i = 0; i < DEPTH; i++) issue(1'b0, AW'((i * 37) % DEPTH), 'x);
      // Per-row interleaved overwrite and read of other columns.
      for (int r = 0; r < NROW; r++) begin
         for (int c = 0; c < NCOL; c++) begin
            issue(1'b1, AW'(r * NCOL + c), DW'((r * 13 + c * 7) ^ 8'hA5));
            issue(1'b0, AW'(r * NCOL + ((c * 5 + 3) % NCOL)), 'x);
         end
      end
      // Alternate between two rows.
      for (int i = 0; i < 16; i++) issue(1'b0, AW'((i % 2) * NCOL + (i % NCOL) + 2 * NCOL), 'x);

      // Reset closes the row; contents survive.
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 R10 mid-run reset");
      rst = 1'b0;
      exp_open = 1'b0;
      @(negedge clk);
      issue(1'b0, AW'(5 * NCOL + 4), 'x);
      issue(1'b0, AW'(5 * NCOL + 1), 'x);
      chk(exp_open == 1'b1, "R10 row reopened", int'(exp_open), 1);

      repeat (4) @(negedge clk);
      chk(overlap_cnt == 0, "R6 strobe overlap cycles", overlap_cnt, 0);
      chk(bus_bad_cnt == 0, "R6 bus data during we_n", bus_bad_cnt, 0);
      chk(addr_move_cnt == 0, "R7 address moves under strobe", addr_move_cnt, 0);
      chk(pre_short_cnt == 0, "R2 short precharge intervals", pre_short_cnt, 0);
      chk(ce_rises == exp_rises, "R3 chip-enable rises", ce_rises, exp_rises);

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule